// File: doc/BRIEF.md
# Word-Parallel CRC-16 Engine for Ultra DMA Bursts

This block keeps a 16-bit cyclic redundancy check over the data words of an Ultra DMA burst. It runs on a word clock derived from the bus strobe, and it folds one whole 16-bit bus word into the checksum per clock. A start pulse loads a fixed seed before the first word. Each word presented with its valid strobe then advances the checksum. A word that arrives past the end of the command is folded in like any other.

At the end of a burst the engine captures its result. In generate mode the captured word is presented bit for bit as the word to send on the bus. In check mode the captured word is also compared with the word received from the far side, and a mismatch is flagged for one cycle together with the completion pulse.

Top module: `udma_crc16`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `crcRun` equals the seed 16'h4ABA, and `endDone` and `mismatch` are low.
- R2: A `burstStart` sampled at a clock edge makes `crcRun` equal 16'h4ABA after that edge. Any `wordValid` word sampled at the same edge is ignored.
- R3: A word sampled with `wordValid` high (and `burstStart` low) sets `crcRun` after that edge to the result of shifting its 16 bits serially through x^16 + x^12 + x^5 + 1. Bit 0 goes in first and bit 15 last. Each step computes feedback = data bit XOR `crcRun[15]`, shifts the register left by one, and XORs 16'h1021 when the feedback is 1. The number of words folded is not limited.
- R4: With `wordValid` and `burstStart` low, `crcRun` keeps its value across the edge.
- R5: A `burstEnd` sampled at an edge raises `endDone` for exactly the following cycle. The captured result includes a word validated at that same edge.
- R6: `finalCrc` carries the captured CRC with CRC bit n on output bit n. It keeps that value until the next `burstEnd`, whatever words follow.
- R7: In check mode (`modeCheck` = 1 at the `burstEnd` edge), `mismatch` is high in the `endDone` cycle exactly when `rxCrc` differs from the captured CRC. `mismatch` is never high outside an `endDone` cycle.
- R8: In generate mode (`modeCheck` = 0 at the `burstEnd` edge), `mismatch` stays low whatever `rxCrc` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock derived from the bus strobe |
| rst_n | input | 1 | Asynchronous active-low reset |
| burstStart | input | 1 | Loads the seed into the running CRC |
| wordValid | input | 1 | Qualifies `wordData` for folding |
| wordData | input | 16 | Data word from or to the bus |
| burstEnd | input | 1 | Ends the burst and captures the result |
| rxCrc | input | 16 | CRC word received from the other side |
| modeCheck | input | 1 | 1 = compare with `rxCrc`, 0 = generate only |
| crcRun | output | 16 | Running CRC register |
| finalCrc | output | 16 | Captured CRC, bit n on bus bit n |
| endDone | output | 1 | One-cycle pulse after `burstEnd` |
| mismatch | output | 1 | Received CRC differs; valid with `endDone` |

## Verification
A wrong term anywhere in the feedback chain appears on `crcRun` one clock after the first word whose bits exercise it. The bench therefore compares `crcRun` after every word against a bit-serial model, using patterns with single set bits and dense patterns. A faulty seed load or hold shows up as the same one-cycle divergence. Capture and compare faults reach `finalCrc`, `endDone` and `mismatch` one cycle after `burstEnd`. These outputs are checked in both modes and with a word arriving on the closing edge.

// File: rtl/udma_crc_pkg.sv
package udma_crc_pkg;

  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

  // strobes from control to datapath
  typedef struct packed {
    logic loadSeed;
    logic fold;
    logic capture;
  } crcStrobes_t;

endpackage

// File: rtl/udma_crc_fold.sv
module udma_crc_fold
  import udma_crc_pkg::*;
#(
  parameter int FOLD_STYLE = 0  // 0: explicit feedback chain, 1: unrolled serial shift
) (
  input  logic [CRC_W-1:0] crcCur,
  input  logic [CRC_W-1:0] dataWord,
  output logic [CRC_W-1:0] crcNext
);

  localparam int LAST = CRC_W - 1;

  generate
    if (FOLD_STYLE == 0 && CRC_W == 16) begin : g_chain
      always_comb begin
        logic [16:1] fb;
        for (int k = 1; k <= 16; k++) begin
          fb[k] = dataWord[k-1] ^ crcCur[16-k];
          if (k >= 5)  fb[k] = fb[k] ^ fb[k-4];
          if (k >= 12) fb[k] = fb[k] ^ fb[k-11];
        end
        for (int i = 0; i < 16; i++) begin
          crcNext[i] = fb[16-i];
          if (i >= 5)  crcNext[i] = crcNext[i] ^ fb[21-i];
          if (i >= 12) crcNext[i] = crcNext[i] ^ fb[28-i];
        end
      end
    end else begin : g_serial
      always_comb begin
        logic [CRC_W-1:0] acc;
        logic             bitFb;
        acc = crcCur;
        for (int b = 0; b < CRC_W; b++) begin
          bitFb = dataWord[b] ^ acc[LAST];
          acc   = {acc[LAST-1:0], 1'b0} ^ (bitFb ? CRC_POLY : '0);
        end
        crcNext = acc;
      end
    end
  endgenerate

endmodule

// File: rtl/udma_crc_datapath.sv
module udma_crc_datapath
  import udma_crc_pkg::*;
#(
  parameter logic [CRC_W-1:0] SEED       = 16'h4ABA,
  parameter int               FOLD_STYLE = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  crcStrobes_t      strobes,
  input  logic [CRC_W-1:0] wordData,
  input  logic [CRC_W-1:0] rxCrc,
  output logic [CRC_W-1:0] crcRun,
  output logic [CRC_W-1:0] finalCrc,
  output logic             diffNow
);

  logic [CRC_W-1:0] crcReg;
  logic [CRC_W-1:0] crcFolded;
  logic [CRC_W-1:0] captureVal;

  udma_crc_fold #(.FOLD_STYLE(FOLD_STYLE)) u_fold (
    .crcCur  (crcReg),
    .dataWord(wordData),
    .crcNext (crcFolded)
  );

  // a word arriving on the closing edge is part of the result
  assign captureVal = strobes.fold ? crcFolded : crcReg;
  assign diffNow    = (captureVal != rxCrc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crcReg <= SEED;
    end else if (strobes.loadSeed) begin
      crcReg <= SEED;
    end else if (strobes.fold) begin
      crcReg <= crcFolded;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      finalCrc <= '0;
    end else if (strobes.capture) begin
      finalCrc <= captureVal;  // bit n stays on bit n
    end
  end

  assign crcRun = crcReg;

endmodule

// File: rtl/udma_crc_ctrl.sv
module udma_crc_ctrl
  import udma_crc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        burstStart,
  input  logic        wordValid,
  input  logic        burstEnd,
  input  logic        modeCheck,
  input  logic        diffNow,
  output crcStrobes_t strobes,
  output logic        endDone,
  output logic        mismatch
);

  always_comb begin
    strobes.loadSeed = burstStart;
    strobes.fold     = wordValid & ~burstStart;
    strobes.capture  = burstEnd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      endDone  <= 1'b0;
      mismatch <= 1'b0;
    end else begin
      endDone  <= burstEnd;
      mismatch <= burstEnd & modeCheck & diffNow;
    end
  end

endmodule

// File: rtl/udma_crc16.sv
module udma_crc16
  import udma_crc_pkg::*;
#(
  parameter logic [15:0] SEED       = 16'h4ABA,
  parameter int          FOLD_STYLE = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        burstStart,
  input  logic        wordValid,
  input  logic [15:0] wordData,
  input  logic        burstEnd,
  input  logic [15:0] rxCrc,
  input  logic        modeCheck,
  output logic [15:0] crcRun,
  output logic [15:0] finalCrc,
  output logic        endDone,
  output logic        mismatch
);

  crcStrobes_t strobes;
  logic        diffNow;

  udma_crc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .burstStart(burstStart),
    .wordValid (wordValid),
    .burstEnd  (burstEnd),
    .modeCheck (modeCheck),
    .diffNow   (diffNow),
    .strobes   (strobes),
    .endDone   (endDone),
    .mismatch  (mismatch)
  );

  udma_crc_datapath #(.SEED(SEED), .FOLD_STYLE(FOLD_STYLE)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .wordData(wordData),
    .rxCrc   (rxCrc),
    .crcRun  (crcRun),
    .finalCrc(finalCrc),
    .diffNow (diffNow)
  );

endmodule

// File: rtl/udma_crc16_checker.sv
module udma_crc16_checker #(
  parameter logic [15:0] SEED = 16'h4ABA
) (
  input logic        clk,
  input logic        rst_n,
  input logic        burstStart,
  input logic        wordValid,
  input logic        burstEnd,
  input logic        modeCheck,
  input logic [15:0] crcRun,
  input logic [15:0] finalCrc,
  input logic        endDone,
  input logic        mismatch
);

  p_seed_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    burstStart |=> crcRun == SEED);

  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!burstStart && !wordValid) |=> $stable(crcRun));

  p_done_follows_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    burstEnd |=> endDone);

  p_done_needs_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    endDone |-> $past(burstEnd));

  p_final_matches_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (endDone && !$past(wordValid)) |-> finalCrc == $past(crcRun));

  p_final_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !burstEnd |=> $stable(finalCrc));

  p_mismatch_in_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> endDone);

  p_gen_mode_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (burstEnd && !modeCheck) |=> !mismatch);

endmodule

bind udma_crc16 udma_crc16_checker #(.SEED(SEED)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .burstStart(burstStart),
  .wordValid (wordValid),
  .burstEnd  (burstEnd),
  .modeCheck (modeCheck),
  .crcRun    (crcRun),
  .finalCrc  (finalCrc),
  .endDone   (endDone),
  .mismatch  (mismatch)
);

// File: tb/udma_crc16_bench.sv
module udma_crc16_bench;

  localparam logic [15:0] SEED = 16'h4ABA;

  // {start, valid, data}
  localparam int NSTIM = 14;
  localparam logic [17:0] STIM [NSTIM] = '{
    {2'b10, 16'h0000}, {2'b01, 16'h0000}, {2'b01, 16'hFFFF}, {2'b00, 16'h0000},
    {2'b01, 16'h1234}, {2'b01, 16'h8001}, {2'b10, 16'h0000}, {2'b01, 16'hA5A5},
    {2'b01, 16'h5A5A}, {2'b00, 16'hFFFF}, {2'b01, 16'h0001}, {2'b01, 16'h8000},
    {2'b01, 16'h0F0F}, {2'b00, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        burstStart = 1'b0;
  logic        wordValid = 1'b0;
  logic [15:0] wordData = '0;
  logic        burstEnd = 1'b0;
  logic [15:0] rxCrc = '0;
  logic        modeCheck = 1'b0;
  logic [15:0] crcRun;
  logic [15:0] finalCrc;
  logic        endDone;
  logic        mismatch;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  logic [15:0] model = SEED;
  logic [15:0] expFinal = '0;

  always #4 clk = ~clk;

  udma_crc16 u_udma_crc16 (
    .clk(clk), .rst_n(rst_n), .burstStart(burstStart), .wordValid(wordValid),
    .wordData(wordData), .burstEnd(burstEnd), .rxCrc(rxCrc), .modeCheck(modeCheck),
    .crcRun(crcRun), .finalCrc(finalCrc), .endDone(endDone), .mismatch(mismatch)
  );

  function automatic logic [15:0] refFold(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] s;
    logic fbit;
    s = c;
    for (int b = 0; b < 16; b++) begin
      fbit = d[b] ^ s[15];
      s = {s[14:0], 1'b0} ^ (fbit ? 16'h1021 : 16'h0000);
    end
    return s;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one cycle; update model; return at the following negedge
  task automatic step(input logic st, input logic vl, input logic [15:0] d,
                      input logic en, input logic [15:0] rx, input logic md);
    burstStart = st; wordValid = vl; wordData = d;
    burstEnd = en; rxCrc = rx; modeCheck = md;
    if (en) expFinal = (vl && !st) ? refFold(model, d) : model;
    if (st) model = SEED;
    else if (vl) model = refFold(model, d);
    @(posedge clk);
    @(negedge clk);
    burstStart = 1'b0; wordValid = 1'b0; burstEnd = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 crcRun in reset", crcRun, SEED);
    check("R1 endDone in reset", {15'd0, endDone}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 crcRun after reset", crcRun, SEED);
    check("R1 mismatch after reset", {15'd0, mismatch}, 16'd0);

    // table walk: R2 seed loads, R3 folds, R4 holds
    for (int i = 0; i < NSTIM; i++) begin
      step(STIM[i][17], STIM[i][16], STIM[i][15:0], 1'b0, 16'h0, 1'b0);
      check(STIM[i][17] ? "R2 seed load" : (STIM[i][16] ? "R3 word fold" : "R4 hold"),
            crcRun, model);
    end

    // R2: word with start is ignored
    step(1'b1, 1'b1, 16'hDEAD, 1'b0, 16'h0, 1'b0);
    check("R2 start ignores word", crcRun, SEED);

    // check mode, correct rx: R5, R7
    step(1'b0, 1'b1, 16'h1111, 1'b0, 16'h0, 1'b1);
    step(1'b0, 1'b1, 16'h2222, 1'b0, 16'h0, 1'b1);
    step(1'b0, 1'b0, 16'h0, 1'b1, model, 1'b1);
    check("R5 endDone pulse", {15'd0, endDone}, 16'd1);
    check("R7 no mismatch on equal", {15'd0, mismatch}, 16'd0);
    check("R6 finalCrc bit order", finalCrc, expFinal);
    step(1'b0, 1'b1, 16'h7777, 1'b0, 16'h0, 1'b1);
    check("R5 endDone single cycle", {15'd0, endDone}, 16'd0);
    check("R6 finalCrc held after extra word", finalCrc, expFinal);

    // check mode, wrong rx, word on closing edge: R5, R7
    step(1'b0, 1'b1, 16'hC3C3, 1'b1, model ^ 16'h0001, 1'b1);
    check("R7 mismatch on differing rx", {15'd0, mismatch}, 16'd1);
    check("R5 capture includes closing word", finalCrc, expFinal);
    check("R3 fold on closing edge", crcRun, model);

    // check mode, closing word makes rx equal: R7
    step(1'b1, 1'b0, 16'h0, 1'b0, 16'h0, 1'b1);
    step(1'b0, 1'b1, 16'h0BAD, 1'b1, refFold(SEED, 16'h0BAD), 1'b1);
    check("R7 closing word compared", {15'd0, mismatch}, 16'd0);

    // generate mode, wrong rx: R8, R6
    step(1'b0, 1'b1, 16'hF00D, 1'b0, 16'h0, 1'b0);
    step(1'b0, 1'b0, 16'h0, 1'b1, ~model, 1'b0);
    check("R8 no mismatch in generate mode", {15'd0, mismatch}, 16'd0);
    check("R8 endDone in generate mode", {15'd0, endDone}, 16'd1);
    check("R6 generated word", finalCrc, expFinal);

    // R1: reset mid-burst
    step(1'b0, 1'b1, 16'h4321, 1'b0, 16'h0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    model = SEED;
    check("R1 reset mid-burst", crcRun, SEED);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule